// File: doc/BRIEF.md
# Systolic Convolution Row with Double-Banked Coefficients

This block computes one row of a large three-dimensional convolution: it slides a 15-tap kernel along a stream of 8-bit unsigned pixels and produces one signed 32-bit partial sum for each accepted pixel once the window is full. The rows, frames and external memories that surround it belong to other blocks. The chain is made of identical processing elements. Every accepted pixel goes to all elements at the same time. Each element multiplies it by its own coefficient, adds the partial sum that the previous element registered, and registers the result. A partial sum therefore moves one element per accepted pixel and leaves the last element as a finished result.

Every element keeps two coefficient banks. The bank that is not computing can be refilled through a serial shift port while the other bank keeps producing results. A swap strobe exchanges the roles of the two banks without a flush. Each partial sum carries a bank tag, so a window that was in flight at the swap finishes with the coefficients it started with. Pixel and result rates therefore stay at one per clock across a kernel change. A start flag on a pixel begins a new stream, and windows that would mix pixels from two streams are not flagged valid.

Top module: `systolic_conv_row`

## Requirements
- R1: While `rst_n` is low at a clock edge, all partial sums, bank tags, the fill counter and `out_valid` are cleared, and the active bank returns to bank 0. After reset, `out_valid` is 0 and `out_sum` is 0.
- R2: For accepted pixels x0 (oldest) to x14 (newest) of one stream, the result is the sum over j = 0..14 of k[j]·x(j), where k[j] is signed 8-bit two's complement and x is unsigned 8-bit. The result appears on `out_sum` with `out_valid` high in the cycle after x14 is accepted.
- R3: Within a stream, the first 14 accepted pixels produce no valid output. The 15th and every later accepted pixel each produce one valid result one cycle later.
- R4: A cycle with `in_valid` low advances nothing. Partial sums hold, `out_valid` is 0 in the following cycle, and windows continue across the gap as if it were absent.
- R5: A `coef_ld` strobe shifts `coef_val` into element 0 of the inactive bank, and each element's inactive coefficient moves to the next element. After 15 strobes, the first value loaded is k[14] and the last value loaded is k[0]. Loading has no effect on results computed from the active bank.
- R6: A `bank_swap` strobe toggles the active bank at the clock edge. A window uses the bank that was active when its oldest pixel was accepted. A pixel accepted in the same cycle as the strobe still uses the old bank.
- R7: A pixel accepted with `in_start` high is the first pixel of a new stream. No valid output follows until 14 further pixels have been accepted.
- R8: A load strobe in the same cycle as a swap strobe writes the bank that was inactive before that edge, which is the bank that becomes active.
- R9: Results at the extremes of the input and coefficient ranges are exact in 32 bits: 15·255·(−128) = −489600 and 15·255·127 = 485775.
- R10: A swap during an unbroken pixel stream causes no bubble. `out_valid` stays high on every cycle that follows an accepted pixel of a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel on `in_pixel` is accepted this cycle |
| in_start | input | 1 | Accepted pixel begins a new stream |
| in_pixel | input | 8 | Unsigned pixel value |
| coef_ld | input | 1 | Shift `coef_val` into the inactive bank |
| coef_val | input | 8 | Signed coefficient to load |
| bank_swap | input | 1 | Toggle the active coefficient bank |
| out_valid | output | 1 | `out_sum` holds a finished window result |
| out_sum | output | 32 | Signed accumulated result |

## Verification
A coefficient load and a bank swap can fall in the same clock edge. They can also coincide with pixels that are still in flight under the old bank. The bench provokes both cases. It shifts the last coefficient of a new kernel in the same cycle as the swap while pixels keep streaming. It also preloads a bank, swaps it in during an unbroken stream, and refills the other bank only after the old windows have drained. Each result is compared with a reference convolution in the bench, which records per pixel the bank it entered under. A misrouted load or a wrongly timed swap therefore shows up as a wrong sum or a dropped valid.

// File: rtl/conv_pkg.sv
// Package: shared defaults and types for the systolic convolution row.
// Assumes: nothing; holds only constants and type definitions.
package conv_pkg;
    localparam int DEF_PIX_W  = 8;
    localparam int DEF_COEF_W = 8;
    localparam int DEF_ACC_W  = 32;
    localparam int DEF_TAPS   = 15;

    // Identifies one of the two coefficient banks in every element.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_t;
endpackage

// File: rtl/conv_bank_ctrl.sv
// Module: conv_bank_ctrl
// Holds the active-bank selector, toggles it on a swap strobe and names the
// inactive bank as the load target for the current cycle.
// Assumes: a swap and a load in the same cycle target the pre-swap inactive bank.
module conv_bank_ctrl
    import conv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  swap,
    output bank_t active,
    output bank_t load_bank
);
    bank_t active_q;

    // Purpose: toggle the active bank on each swap strobe and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= BANK_0;
        end else if (swap) begin
            active_q <= (active_q == BANK_0) ? BANK_1 : BANK_0;
        end
    end

    assign active    = active_q;
    assign load_bank = (active_q == BANK_0) ? BANK_1 : BANK_0;

    a_r6_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> active_q != $past(active_q));
    a_r6_no_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(active_q));
endmodule

// File: rtl/conv_fill_track.sv
// Module: conv_fill_track
// Counts accepted pixels of the current stream, saturating at the tap count,
// and flags a result valid one cycle after a pixel that completes a window.
// Assumes: in_start is only meaningful together with in_valid.
module conv_fill_track #(
    parameter int TAPS = conv_pkg::DEF_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    output logic out_valid
);
    localparam int CNT_W = $clog2(TAPS + 1);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(TAPS);
    localparam logic [CNT_W-1:0] ONE_SHY = CNT_W'(TAPS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;

    // Purpose: advance the fill count per accepted pixel and derive the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (in_valid) begin
                if (in_start) begin
                    cnt_q   <= CNT_W'(1);
                    valid_q <= (TAPS == 1);
                end else begin
                    if (cnt_q < FULL) cnt_q <= cnt_q + CNT_W'(1);
                    valid_q <= (cnt_q >= ONE_SHY);
                end
            end
        end
    end

    assign out_valid = valid_q;

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    a_r4_valid_needs_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(in_valid));
    generate
        if (TAPS > 1) begin : g_restart_chk
            a_r7_restart_blanks: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_start) |=> !valid_q);
        end
    endgenerate
endmodule

// File: rtl/conv_pe.sv
// Module: conv_pe
// One processing element: two coefficient banks on a serial shift chain, and a
// multiply-add stage that registers partial sum and bank tag per accepted pixel.
// Assumes: the pixel is broadcast; the bank being loaded holds no in-flight tag.
module conv_pe
    import conv_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [PIX_W-1:0]         pixel,
    input  logic signed [ACC_W-1:0]  sum_in,
    input  bank_t                    tag_in,
    input  logic                     ld,
    input  bank_t                    ld_bank,
    input  logic signed [COEF_W-1:0] coef_in,
    output logic signed [COEF_W-1:0] coef_out,
    output logic signed [ACC_W-1:0]  sum_out,
    output bank_t                    tag_out
);
    localparam int PROD_W = PIX_W + 1 + COEF_W;

    logic signed [COEF_W-1:0] bank_q [2];
    logic signed [ACC_W-1:0]  sum_q;
    bank_t                    tag_q;
    logic signed [COEF_W-1:0] coef_sel;
    logic signed [PROD_W-1:0] px_e;
    logic signed [PROD_W-1:0] cf_e;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_e;

    // Purpose: shift a new coefficient into the bank that is being loaded.
    always_ff @(posedge clk) begin
        if (ld) bank_q[ld_bank] <= coef_in;
    end

    // Purpose: form the signed product of the pixel and the tagged coefficient.
    always_comb begin
        coef_sel = bank_q[tag_in];
        px_e     = {{(PROD_W - PIX_W){1'b0}}, pixel};
        cf_e     = {{(PROD_W - COEF_W){coef_sel[COEF_W-1]}}, coef_sel};
        prod     = px_e * cf_e;
        prod_e   = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Purpose: register partial sum and bank tag when a pixel is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            tag_q <= BANK_0;
        end else if (adv) begin
            sum_q <= sum_in + prod_e;
            tag_q <= tag_in;
        end
    end

    assign coef_out = bank_q[ld_bank];
    assign sum_out  = sum_q;
    assign tag_out  = tag_q;

    a_r4_stall_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sum_q));
    a_r6_tag_travels: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> tag_q == $past(tag_in));
endmodule

// File: rtl/systolic_conv_row.sv
// Module: systolic_conv_row (top)
// A chain of TAPS processing elements computing a sliding window convolution
// of one pixel row, with background kernel loading and tagged bank swapping.
// Assumes: a bank is reloaded only after windows tagged with it have drained.
module systolic_conv_row
    import conv_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int TAPS   = DEF_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              coef_ld,
    input  logic [COEF_W-1:0] coef_val,
    input  logic              bank_swap,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_sum
);
    localparam int LAST = TAPS - 1;

    bank_t                    active;
    bank_t                    load_bank;
    logic signed [ACC_W-1:0]  sum_w  [TAPS];
    bank_t                    tag_w  [TAPS];
    logic signed [COEF_W-1:0] coef_w [TAPS];
    logic                     fill_valid;

    conv_bank_ctrl u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (bank_swap),
        .active    (active),
        .load_bank (load_bank)
    );

    conv_fill_track #(.TAPS(TAPS)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .out_valid (fill_valid)
    );

    genvar i;
    generate
        for (i = 0; i < TAPS; i++) begin : g_pe
            logic signed [ACC_W-1:0]  s_in;
            bank_t                    t_in;
            logic signed [COEF_W-1:0] c_in;
            if (i == 0) begin : g_head
                assign s_in = '0;
                assign t_in = active;
                assign c_in = $signed(coef_val);
            end else begin : g_body
                assign s_in = sum_w[i-1];
                assign t_in = tag_w[i-1];
                assign c_in = coef_w[i-1];
            end
            conv_pe #(
                .PIX_W  (PIX_W),
                .COEF_W (COEF_W),
                .ACC_W  (ACC_W)
            ) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv      (in_valid),
                .pixel    (in_pixel),
                .sum_in   (s_in),
                .tag_in   (t_in),
                .ld       (coef_ld),
                .ld_bank  (load_bank),
                .coef_in  (c_in),
                .coef_out (coef_w[i]),
                .sum_out  (sum_w[i]),
                .tag_out  (tag_w[i])
            );
        end
    endgenerate

    assign out_valid = fill_valid;
    assign out_sum   = sum_w[LAST];

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sum == '0));
    a_r10_swap_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_swap && in_valid && !in_start && $past(out_valid) && $past(in_valid)
         && !$past(in_start)) |=> out_valid);
endmodule

// File: tb/systolic_conv_row_test.sv
// Directed bench for systolic_conv_row with a reference convolution model.
module systolic_conv_row_test;
    localparam int TAPS = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic [7:0]  in_pixel = '0;
    logic        coef_ld = 1'b0;
    logic [7:0]  coef_val = '0;
    logic        bank_swap = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int mk [2][TAPS];
    int hx [512];
    int hb [512];
    int cnt = 0;
    int mbank = 0;
    int kv [TAPS];

    systolic_conv_row uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_pixel(in_pixel), .coef_ld(coef_ld), .coef_val(coef_val),
        .bank_swap(bank_swap), .out_valid(out_valid), .out_sum(out_sum)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic av, input logic ev,
                         input int as, input int es);
        total++;
        if (av !== ev || (ev && as != es)) begin
            bad++;
            $display("FAIL %s valid=%0b sum=%0d expected valid=%0b sum=%0d",
                     tag, av, as, ev, es);
        end
    endtask

    // One clock: drive at a falling edge, sample at the next falling edge.
    task automatic step(input logic v, input int px, input logic st, input logic ld,
                        input int cv, input logic sw, input string tag);
        int e;
        logic ev;
        in_valid = v; in_pixel = px[7:0]; in_start = st;
        coef_ld = ld; coef_val = cv[7:0]; bank_swap = sw;
        @(negedge clk);
        in_valid = 0; in_start = 0; coef_ld = 0; bank_swap = 0;
        e = 0; ev = 0;
        if (v) begin
            if (st) cnt = 0;
            if (cnt < 512) begin
                hx[cnt] = px & 255; hb[cnt] = mbank; cnt++;
            end
            if (cnt >= TAPS) begin
                ev = 1;
                for (int j = 0; j < TAPS; j++)
                    e += mk[hb[cnt-TAPS]][j] * hx[cnt-TAPS+j];
            end
        end
        if (ld) begin
            for (int j = TAPS - 1; j > 0; j--) mk[1-mbank][j] = mk[1-mbank][j-1];
            mk[1-mbank][0] = $signed(cv[7:0]);
        end
        if (sw) mbank = 1 - mbank;
        check(tag, out_valid, ev, $signed(out_sum), e);
    endtask

    // Load kv into the inactive bank, k[14] first; optionally stream pixels
    // meanwhile and optionally swap on the last strobe.
    task automatic load_kernel(input logic stream, input int seed,
                               input logic swap_last, input string tag);
        for (int j = TAPS - 1; j >= 0; j--)
            step(stream, (seed + j * 29) % 256, 1'b0, 1'b1, kv[j],
                 swap_last && (j == 0), tag);
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", out_valid, 1'b0, 0, 0);
        total++;
        if (out_sum !== 32'd0) begin
            bad++;
            $display("FAIL R1 sum=%0d expected sum=0", out_sum);
        end
    endtask

    task automatic t_first_kernel;
        for (int j = 0; j < TAPS; j++) kv[j] = j * 9 - 60;
        load_kernel(1'b0, 0, 1'b0, "R5");
        step(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, "R6");
        for (int i = 0; i < 30; i++)
            step(1'b1, (i * 17 + 3) % 256, i == 0, 1'b0, 0, 1'b0, i < 15 ? "R3" : "R2");
    endtask

    task automatic t_stalls;
        for (int i = 0; i < 20; i++)
            step(i % 2 == 0, (i % 4 < 2) ? 255 : 0, 1'b0, 1'b0, 0, 1'b0, "R4");
    endtask

    task automatic t_swap_stream;
        for (int j = 0; j < TAPS; j++) kv[j] = 100 - j * 13;
        load_kernel(1'b1, 7, 1'b0, "R5");
        step(1'b1, 77, 1'b0, 1'b0, 0, 1'b1, "R6");
        for (int i = 0; i < 30; i++)
            step(1'b1, (i * 73 + 11) % 256, 1'b0, 1'b0, 0, 1'b0, "R10");
    endtask

    task automatic t_restart;
        for (int i = 0; i < 20; i++)
            step(1'b1, (i * 41 + 5) % 256, i == 0, 1'b0, 0, 1'b0, "R7");
    endtask

    task automatic t_load_with_swap;
        for (int j = 0; j < TAPS; j++) kv[j] = (j % 3 == 0) ? -128 : j * 5;
        load_kernel(1'b1, 19, 1'b1, "R8");
        for (int i = 0; i < 20; i++)
            step(1'b1, (i * 37 + 2) % 256, 1'b0, 1'b0, 0, 1'b0, "R8");
    endtask

    task automatic t_extremes;
        for (int j = 0; j < TAPS; j++) kv[j] = -128;
        load_kernel(1'b0, 0, 1'b1, "R9");
        for (int i = 0; i < 20; i++)
            step(1'b1, 255, i == 0, 1'b0, 0, 1'b0, "R9");
        total++;
        if ($signed(out_sum) != -489600) begin
            bad++;
            $display("FAIL R9 sum=%0d expected sum=-489600", $signed(out_sum));
        end
        for (int j = 0; j < TAPS; j++) kv[j] = 127;
        load_kernel(1'b0, 0, 1'b1, "R9");
        for (int i = 0; i < 20; i++)
            step(1'b1, 255, 1'b0, 1'b0, 0, 1'b0, "R9");
        total++;
        if ($signed(out_sum) != 485775) begin
            bad++;
            $display("FAIL R9 sum=%0d expected sum=485775", $signed(out_sum));
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_kernel();
        t_stalls();
        t_swap_stream();
        t_restart();
        t_load_with_swap();
        t_extremes();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule